// File: doc/BRIEF.md
# Up-Counting Timer with Shadowed Period and Event Capture

This block is a free-running up counter that advances once for each active edge of a timer tick input. A polarity input picks the rising or falling tick edge. The counter is compared against an active period value. When the count steps up to that period, a one-cycle match pulse is produced. On the next tick the counter returns to zero; this is the reset event of the timer.

Software changes the period while the timer runs. It writes bytes into a shadow register. Only a write to the lowest byte arms the shadow. The armed value moves into the active period at the next reset event, so a period never changes in the middle of a count cycle.

A capture register takes a snapshot of the count in one clock. The snapshot can come from a command bit, from stop events, or from edges of an external start/reset line. Which of these sources apply depends on the stop-source setting. A single read port returns either the live count or the captured value, chosen by a read-select bit.

Top module: `buffered_period_timer`

## Requirements
- R1: The count rises by exactly one for each active edge of `tick_i`. The active edge is rising when `tick_fall_i`=0 and falling when `tick_fall_i`=1. In any other cycle the count holds.
- R2: When a tick moves the count from period-1 to period, `match_o` is high for exactly the one clock that follows that tick.
- R3: A tick that arrives while the count equals the active period clears the count to zero. This is the reset event. The count never exceeds the active period.
- R4: A write with `wr_addr_i` in 0..BYTES-1 stores `wr_data_i` into that byte of the shadow period. Address 0 is the least significant byte. Writes to the upper addresses do not arm the shadow, and an unarmed shadow never changes the period.
- R5: A write to address 0 arms the shadow. At the next reset event the shadow becomes the active period and the arm flag clears.
- R6: A write to the control address (BYTES) with data bit 0 set copies the current count into the capture register at that clock edge. Without a capture event, the capture register holds its value.
- R7: When `stop_sel_i` is nonzero, stop events capture the count and external edges are ignored. The codes are: 1 = `stop_i` high; 2 = the cycle in which `match_o` is high; 3 = either of the two.
- R8: When `stop_sel_i` is 0, an edge of `ext_i` captures the count. The edge is rising when `ext_fall_i`=0 and falling when it is 1. After two synchronizer flops, the capture register changes at the third clock edge after `ext_i` changes.
- R9: Control data bit 1 is the read select. When it is 1, `rd_data_o` shows the count; when it is 0, it shows the capture register. Capture events update the capture register for either setting.
- R10: After reset the count, the capture register, the read select and `match_o` are zero, the shadow is unarmed, and the active period equals PERIOD_RST.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timer tick, synchronous to clk |
| tick_fall_i | input | 1 | 1 selects the falling tick edge |
| ext_i | input | 1 | Asynchronous external start/reset line |
| ext_fall_i | input | 1 | 1 selects the falling external edge |
| stop_i | input | 1 | Stop event strobe |
| stop_sel_i | input | 2 | Stop source: 0 none, 1 strobe, 2 match, 3 both |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Period byte index or control address |
| wr_data_i | input | 8 | Write data byte |
| rd_data_o | output | CNT_W | Count or captured value |
| match_o | output | 1 | Period match pulse |

## Verification
The counter is driven with runs of ticks of different lengths from a fixed period. These runs separate plain stepping, the match pulse at the period, and the clear on the following tick. Period updates are tried three ways: an upper-byte write alone, an armed write made in the middle of a count cycle, and a restore. These cases show that the new period takes effect only after a reset event, and only when the shadow was armed. The capture sources are tried one at a time. Each changes the count between events, so a missed capture, a capture one cycle late, or a capture from a source the stop setting should mask each leaves a different value in the capture register.

// File: rtl/timer_pkg.sv
package timer_pkg;

  typedef enum logic [1:0] {
    STOP_NONE   = 2'd0,
    STOP_PIN    = 2'd1,
    STOP_MATCH  = 2'd2,
    STOP_EITHER = 2'd3
  } stop_src_e;

  localparam int unsigned CTRL_CAPT_BIT  = 0;
  localparam int unsigned CTRL_RDSEL_BIT = 1;

endpackage

// File: rtl/tmr_edge_det.sv
module tmr_edge_det #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  input  logic fall_sel_i,
  output logic edge_o
);

  logic cur;
  logic prev_q;

  generate
    if (SYNC_STAGES == 0) begin : g_direct
      assign cur = sig_i;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] sync_q;
      logic [SYNC_STAGES-1:0] sync_d;

      always_comb begin
        sync_d[0] = sig_i;
        for (int i = 1; i < int'(SYNC_STAGES); i++) begin
          sync_d[i] = sync_q[i-1];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sync_q <= '0;
        end else begin
          sync_q <= sync_d;
        end
      end

      assign cur = sync_q[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
    end else begin
      prev_q <= cur;
    end
  end

  always_comb begin
    if (fall_sel_i) begin
      edge_o = prev_q & ~cur;
    end else begin
      edge_o = cur & ~prev_q;
    end
  end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] count_o,
  output logic             match_o,
  output logic             rst_evt_o
);

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_d;
  logic             match_q;
  logic             match_d;
  logic             rst_evt;

  always_comb begin
    rst_evt = tick_i && (count_q == period_i);
    count_d = count_q;
    match_d = 1'b0;
    if (rst_evt) begin
      count_d = '0;
    end else if (tick_i) begin
      count_d = count_q + 1'b1;
      match_d = (count_d == period_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (tick_i) begin
      count_q <= count_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= 1'b0;
    end else begin
      match_q <= match_d;
    end
  end

  assign count_o   = count_q;
  assign match_o   = match_q;
  assign rst_evt_o = rst_evt;

endmodule

// File: rtl/tmr_period_buf.sv
module tmr_period_buf #(
  parameter int unsigned     CNT_W      = 16,
  parameter logic [CNT_W-1:0] PERIOD_RST = '1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [CNT_W/8-1:0]    lane_we_i,
  input  logic [7:0]            wr_data_i,
  input  logic                  rst_evt_i,
  output logic [CNT_W-1:0]      period_o,
  output logic                  armed_o
);

  localparam int unsigned BYTES = CNT_W / 8;

  logic [BYTES-1:0][7:0] shadow_q;
  logic [BYTES-1:0][7:0] shadow_d;
  logic [CNT_W-1:0]      period_q;
  logic [CNT_W-1:0]      period_d;
  logic                  armed_q;
  logic                  armed_d;
  logic                  shadow_en;
  logic                  period_en;

  always_comb begin
    shadow_d = shadow_q;
    for (int l = 0; l < int'(BYTES); l++) begin
      if (lane_we_i[l]) begin
        shadow_d[l] = wr_data_i;
      end
    end
    shadow_en = |lane_we_i;
  end

  always_comb begin
    period_d  = period_q;
    armed_d   = armed_q;
    period_en = 1'b0;
    if (rst_evt_i && armed_q) begin
      period_d  = shadow_q;
      armed_d   = 1'b0;
      period_en = 1'b1;
    end
    if (lane_we_i[0]) begin
      armed_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= PERIOD_RST;
    end else if (shadow_en) begin
      shadow_q <= shadow_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= PERIOD_RST;
    end else if (period_en) begin
      period_q <= period_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else begin
      armed_q <= armed_d;
    end
  end

  assign period_o = period_q;
  assign armed_o  = armed_q;

endmodule

// File: rtl/tmr_capture.sv
module tmr_capture
  import timer_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_i,
  input  logic             stop_pin_i,
  input  logic             match_i,
  input  logic             ext_edge_i,
  input  stop_src_e        stop_sel_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [CNT_W-1:0] cap_o,
  output logic             cap_evt_o
);

  logic [CNT_W-1:0] cap_q;
  logic             pin_hit;
  logic             match_hit;
  logic             ext_hit;
  logic             cap_evt;

  always_comb begin
    pin_hit   = stop_pin_i && ((stop_sel_i == STOP_PIN) || (stop_sel_i == STOP_EITHER));
    match_hit = match_i && ((stop_sel_i == STOP_MATCH) || (stop_sel_i == STOP_EITHER));
    ext_hit   = ext_edge_i && (stop_sel_i == STOP_NONE);
    cap_evt   = cmd_i || pin_hit || match_hit || ext_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= '0;
    end else if (cap_evt) begin
      cap_q <= count_i;
    end
  end

  assign cap_o     = cap_q;
  assign cap_evt_o = cap_evt;

endmodule

// File: rtl/buffered_period_timer.sv
module buffered_period_timer
  import timer_pkg::*;
#(
  parameter int unsigned      CNT_W      = 16,
  parameter logic [CNT_W-1:0] PERIOD_RST = '1,
  parameter int unsigned      EXT_SYNC   = 2,
  localparam int unsigned     BYTES      = CNT_W / 8,
  localparam int unsigned     ADDR_W     = $clog2(BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              tick_fall_i,
  input  logic              ext_i,
  input  logic              ext_fall_i,
  input  logic              stop_i,
  input  logic [1:0]        stop_sel_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  output logic [CNT_W-1:0]  rd_data_o,
  output logic              match_o
);

  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(BYTES);

  stop_src_e        stop_sel;
  logic             tick_evt;
  logic             ext_evt;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] period_act;
  logic             armed;
  logic             rst_evt;
  logic [CNT_W-1:0] cap_val;
  logic             cap_evt;
  logic [BYTES-1:0] lane_we;
  logic             ctrl_we;
  logic             capt_cmd;
  logic             rdsel_q;
  logic             rdsel_d;

  assign stop_sel = stop_src_e'(stop_sel_i);

  genvar gl;
  generate
    for (gl = 0; gl < BYTES; gl++) begin : g_lane
      assign lane_we[gl] = wr_en_i && (wr_addr_i == ADDR_W'(gl));
    end
  endgenerate

  assign ctrl_we  = wr_en_i && (wr_addr_i == CTRL_ADDR);
  assign capt_cmd = ctrl_we && wr_data_i[CTRL_CAPT_BIT];

  always_comb begin
    rdsel_d = rdsel_q;
    if (ctrl_we) begin
      rdsel_d = wr_data_i[CTRL_RDSEL_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdsel_q <= 1'b0;
    end else if (ctrl_we) begin
      rdsel_q <= rdsel_d;
    end
  end

  tmr_edge_det #(.SYNC_STAGES(0)) u_tick_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .sig_i     (tick_i),
    .fall_sel_i(tick_fall_i),
    .edge_o    (tick_evt)
  );

  tmr_edge_det #(.SYNC_STAGES(EXT_SYNC)) u_ext_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .sig_i     (ext_i),
    .fall_sel_i(ext_fall_i),
    .edge_o    (ext_evt)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick_evt),
    .period_i (period_act),
    .count_o  (count),
    .match_o  (match_o),
    .rst_evt_o(rst_evt)
  );

  tmr_period_buf #(.CNT_W(CNT_W), .PERIOD_RST(PERIOD_RST)) u_period (
    .clk      (clk),
    .rst_n    (rst_n),
    .lane_we_i(lane_we),
    .wr_data_i(wr_data_i),
    .rst_evt_i(rst_evt),
    .period_o (period_act),
    .armed_o  (armed)
  );

  tmr_capture #(.CNT_W(CNT_W)) u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_i     (capt_cmd),
    .stop_pin_i(stop_i),
    .match_i   (match_o),
    .ext_edge_i(ext_evt),
    .stop_sel_i(stop_sel),
    .count_i   (count),
    .cap_o     (cap_val),
    .cap_evt_o (cap_evt)
  );

  assign rd_data_o = rdsel_q ? count : cap_val;

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_evt,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] period,
  input logic             armed,
  input logic             rst_evt,
  input logic             match,
  input logic [CNT_W-1:0] cap,
  input logic             cap_evt
);

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_evt |=> $stable(count));

  assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_evt && !rst_evt) |=> (count == CNT_W'($past(count) + 1'b1)));

  assert_match_at_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
    match |-> (count == period));

  assert_match_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> !match);

  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_evt |=> (count == '0));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= period);

  assert_load_on_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(armed) |-> $past(rst_evt));

  assert_period_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_evt |=> $stable(period));

  assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (cap == $past(count)));

  assert_capture_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_evt |=> $stable(cap));

endmodule

bind buffered_period_timer tmr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tick_evt(tick_evt),
  .count   (count),
  .period  (period_act),
  .armed   (armed),
  .rst_evt (rst_evt),
  .match   (match_o),
  .cap     (cap_val),
  .cap_evt (cap_evt)
);

// File: tb/buffered_period_timer_bench.sv
module buffered_period_timer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 16;
  localparam int BYTES      = CNT_W / 8;
  localparam int ADDR_W     = $clog2(BYTES + 1);
  localparam int PER0       = 6;

  // {tick count, expected count, expected match on last tick}
  localparam logic [24:0] VEC [0:7] = '{
    {8'd1, 16'd1, 1'b0},
    {8'd3, 16'd4, 1'b0},
    {8'd1, 16'd5, 1'b0},
    {8'd1, 16'd6, 1'b1},
    {8'd1, 16'd0, 1'b0},
    {8'd2, 16'd2, 1'b0},
    {8'd4, 16'd6, 1'b1},
    {8'd1, 16'd0, 1'b0}
  };

  logic              clk;
  logic              rst_n;
  logic              tick_i;
  logic              tick_fall_i;
  logic              ext_i;
  logic              ext_fall_i;
  logic              stop_i;
  logic [1:0]        stop_sel_i;
  logic              wr_en_i;
  logic [ADDR_W-1:0] wr_addr_i;
  logic [7:0]        wr_data_i;
  logic [CNT_W-1:0]  rd_data_o;
  logic              match_o;

  int n_chk;
  int n_bad;
  int exp_cnt;
  int exp_per;
  int exp_shadow;
  int exp_cap;
  bit exp_armed;
  bit exp_rdsel;

  buffered_period_timer #(.CNT_W(CNT_W), .PERIOD_RST(16'(PER0))) u_buffered_period_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .tick_fall_i(tick_fall_i),
    .ext_i      (ext_i),
    .ext_fall_i (ext_fall_i),
    .stop_i     (stop_i),
    .stop_sel_i (stop_sel_i),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .rd_data_o  (rd_data_o),
    .match_o    (match_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    wr_addr_i = ADDR_W'(addr);
    wr_data_i = 8'(data);
    wr_en_i   = 1'b1;
    @(negedge clk);
    wr_en_i   = 1'b0;
    if (addr < BYTES) begin
      exp_shadow = (exp_shadow & ~(255 << (8*addr))) | ((data & 255) << (8*addr));
      if (addr == 0) exp_armed = 1'b1;
    end else begin
      if (data[0]) exp_cap = exp_cnt;
      exp_rdsel = data[1];
    end
  endtask

  task automatic tick_once(output bit m, output bit em);
    tick_i = 1'b1;
    @(negedge clk);
    m = match_o;
    tick_i = 1'b0;
    @(negedge clk);
    em = 1'b0;
    if (exp_cnt == exp_per) begin
      exp_cnt = 0;
      if (exp_armed) begin
        exp_per   = exp_shadow;
        exp_armed = 1'b0;
      end
    end else begin
      exp_cnt = exp_cnt + 1;
      em = (exp_cnt == exp_per);
    end
  endtask

  task automatic tick_chk(input int n, input string tag);
    bit m;
    bit em;
    for (int i = 0; i < n; i++) begin
      tick_once(m, em);
      chk({tag, " match"}, int'(m), int'(em));
      if (exp_rdsel) chk({tag, " count"}, int'(rd_data_o), exp_cnt);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic model_reset();
    exp_cnt    = 0;
    exp_per    = PER0;
    exp_shadow = PER0;
    exp_cap    = 0;
    exp_armed  = 1'b0;
    exp_rdsel  = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    bit m;
    bit em;
    n_chk = 0;
    n_bad = 0;
    rst_n = 1'b0;
    tick_i = 1'b0; tick_fall_i = 1'b0; ext_i = 1'b0; ext_fall_i = 1'b0;
    stop_i = 1'b0; stop_sel_i = 2'd0;
    wr_en_i = 1'b0; wr_addr_i = '0; wr_data_i = '0;
    model_reset();
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R10: reset state
    chk("R10 match", int'(match_o), 0);
    chk("R10 capture", int'(rd_data_o), 0);
    wr(BYTES, 2);
    chk("R10 count", int'(rd_data_o), 0);

    // R1 R2 R3: table of tick runs with period PER0
    for (int v = 0; v < 8; v++) begin
      for (int i = 0; i < int'(VEC[v][24:17]); i++) begin
        tick_once(m, em);
      end
      chk("R1 vector count", int'(rd_data_o), int'(VEC[v][16:1]));
      chk("R2 vector match", int'(m), int'(VEC[v][0]));
    end

    // R1: falling tick polarity
    tick_fall_i = 1'b1;
    idle(1);
    tick_i = 1'b1;
    idle(1);
    chk("R1 rising ignored", int'(rd_data_o), 0);
    tick_i = 1'b0;
    idle(1);
    exp_cnt = 1;
    chk("R1 falling counts", int'(rd_data_o), 1);
    tick_fall_i = 1'b0;
    idle(1);

    // R4 R5: armed mid-cycle, loads only after reset event
    wr(1, 8'h00);
    wr(0, 8'd3);
    tick_chk(9, "R5 armed load");
    chk("R5 count at new period", int'(rd_data_o), 3);
    // R4: upper byte alone does not arm
    wr(1, 8'h01);
    tick_chk(8, "R4 upper only");
    tick_chk(1, "R4 wrap");
    wr(1, 8'h00);
    wr(0, PER0);
    tick_chk(4, "R5 restore");

    // R6 R9: capture command and read select
    tick_chk(2, "R6 setup");
    wr(BYTES, 3);
    chk("R9 live count", int'(rd_data_o), exp_cnt);
    tick_chk(1, "R9 setup");
    wr(BYTES, 0);
    chk("R6 R9 captured", int'(rd_data_o), 2);

    // R8: rising external edge, latency of three edges
    ext_i = 1'b1;
    idle(1);
    chk("R8 no early capture", int'(rd_data_o), 2);
    idle(1);
    chk("R8 no early capture", int'(rd_data_o), 2);
    idle(1);
    chk("R8 rising capture", int'(rd_data_o), 3);

    // R8: falling polarity
    tick_chk(1, "R8 setup");
    ext_fall_i = 1'b1;
    idle(4);
    chk("R8 polarity switch quiet", int'(rd_data_o), 3);
    ext_i = 1'b0;
    idle(3);
    chk("R8 falling capture", int'(rd_data_o), 4);
    tick_chk(1, "R8 setup");
    ext_i = 1'b1;
    idle(4);
    chk("R8 rising ignored", int'(rd_data_o), 4);

    // R7: stop strobe mode, external edges masked
    stop_sel_i = 2'd1;
    ext_i = 1'b0;
    idle(4);
    chk("R7 ext masked", int'(rd_data_o), 4);
    stop_i = 1'b1;
    idle(1);
    stop_i = 1'b0;
    chk("R7 strobe capture", int'(rd_data_o), 5);

    // R7: match mode
    stop_sel_i = 2'd2;
    idle(1);
    tick_chk(1, "R7 match");
    chk("R7 match capture", int'(rd_data_o), 6);
    tick_chk(1, "R7 wrap");
    stop_i = 1'b1;
    idle(1);
    stop_i = 1'b0;
    chk("R7 strobe masked", int'(rd_data_o), 6);

    // R7: either mode
    stop_sel_i = 2'd3;
    idle(1);
    tick_chk(2, "R7 either");
    stop_i = 1'b1;
    idle(1);
    stop_i = 1'b0;
    chk("R7 either strobe", int'(rd_data_o), 2);

    // R10: reset in mid-run
    stop_sel_i = 2'd0;
    ext_fall_i = 1'b0;
    wr(0, 8'd2);
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    model_reset();
    idle(1);
    chk("R10 capture cleared", int'(rd_data_o), 0);
    wr(BYTES, 2);
    chk("R10 count cleared", int'(rd_data_o), 0);
    tick_chk(7, "R10 period restored");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule